// File: doc/BRIEF.md
# Line-Period Reciprocal Counter

This block measures the period of a mains-frequency square wave. An external comparator produces the wave: it is logic 1 while the sine is above its mid-level and 0 while it is below. The block measures by counting ticks of its own clock between zero-crossing edges. The clock is nominally a 10 MHz reference, so one tick is 100 ns. A full 50 Hz or 60 Hz cycle at that rate needs an 18-bit count.

The comparator output arrives asynchronously. It first passes through a two-flop synchroniser. An optional deglitch filter then rejects chatter near the crossing: a level change counts only once it has held for a set number of ticks. Rising and falling edges of the filtered level are found next. The high half-cycle and the low half-cycle are timed separately, and each result carries a one-cycle strobe. After every rising edge the block also publishes their sum as the full period.

The first edge after reset only arms the timer, so no partial interval is ever reported. The interval counter saturates at all-ones if an edge fails to arrive. When that happens the interval is dropped and a sticky overflow flag is raised.

Top module: `line_period_meter`

## Requirements
- R1: A level change of `line_i` that lasts fewer than `FILT_TICKS` consecutive clock cycles is ignored when the filter is enabled: it produces no strobe and does not alter any reported count.
- R2: While `rst_ni` is low, every output is 0.
- R3: The first detected edge after reset only arms the timer; no strobe is issued until a second edge is detected.
- R4: On each falling edge (1 to 0), `pos_cnt_o` is loaded with the number of clock cycles since the preceding rising edge, and `pos_valid_o` pulses for one cycle. With an asynchronous input the count lies within ±2 of the true interval.
- R5: On each rising edge (0 to 1), `neg_cnt_o` is loaded with the number of clock cycles since the preceding falling edge, and `neg_valid_o` pulses for one cycle. The count lies within ±2 of the true interval.
- R6: On a rising edge that ends a valid low interval, which itself followed a valid high interval, `per_cnt_o` is loaded with `pos_cnt_o + neg_cnt_o` and `per_valid_o` pulses in the same cycle as `neg_valid_o`.
- R7: The interval counter saturates at 2^`CNT_W`-1. An interval that reaches this value issues no strobe and sets `ovf_o`, which stays 1 until reset. No period strobe is issued for a cycle that contains an overflowed half.
- R8: `pos_valid_o` and `neg_valid_o` are never high in the same cycle.
- R9: Polarity is fixed: `line_i` = 1 marks the high (positive) half, which is reported on `pos_cnt_o`. `line_i` = 0 marks the negative half, which is reported on `neg_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous comparator output, 1 above mid-level |
| pos_cnt_o | output | CNT_W | Last high half-cycle length in ticks |
| pos_valid_o | output | 1 | One-cycle strobe for a new `pos_cnt_o` |
| neg_cnt_o | output | CNT_W | Last low half-cycle length in ticks |
| neg_valid_o | output | 1 | One-cycle strobe for a new `neg_cnt_o` |
| per_cnt_o | output | CNT_W+1 | Last full period in ticks |
| per_valid_o | output | 1 | One-cycle strobe for a new `per_cnt_o` |
| ovf_o | output | 1 | Sticky flag: an interval reached the saturation value |

## Verification
Several rules are checked by the assertions on every cycle:
- the two half-cycle strobes are exclusive;
- a period strobe coincides with a low-half strobe and equals the sum of the held half counts;
- a strobed count is never the saturated value;
- overflow, once set, persists.

Other behaviour shows only in the bench's scenarios: the tick counts themselves under sub-cycle edge jitter, rejection of short glitches, arming on the first edge, and loss of exactly the overflowed interval. The bench sweeps symmetric, strongly asymmetric and near-limit half-cycle lengths on a narrowed counter.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lpm_deglitch.sv
module lpm_deglitch #(
  parameter bit FILT_EN    = 1'b1,
  parameter int FILT_TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o
);
  generate
    if (FILT_EN && FILT_TICKS > 1) begin : g_filt
      localparam int CW = $clog2(FILT_TICKS);
      logic [CW-1:0] run_q;
      logic          lvl_q;

      // accept a new level only after FILT_TICKS consecutive cycles
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          run_q <= '0;
          lvl_q <= 1'b0;
        end else if (d_i == lvl_q) begin
          run_q <= '0;
        end else if (run_q == CW'(FILT_TICKS - 1)) begin
          lvl_q <= d_i;
          run_q <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end

      assign lvl_o = lvl_q;
    end else begin : g_bypass
      assign lvl_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/lpm_interval.sv
module lpm_interval
  import lpm_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_t            edge_i,
  output logic [CNT_W-1:0] pos_cnt_o,
  output logic             pos_valid_o,
  output logic [CNT_W-1:0] neg_cnt_o,
  output logic             neg_valid_o,
  output logic [CNT_W:0]   per_cnt_o,
  output logic             per_valid_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             pos_ok_q;
  logic             any_edge;
  logic             sat;

  assign any_edge = edge_i.rise | edge_i.fall;
  assign sat      = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      pos_ok_q    <= 1'b0;
      pos_cnt_o   <= '0;
      neg_cnt_o   <= '0;
      per_cnt_o   <= '0;
      pos_valid_o <= 1'b0;
      neg_valid_o <= 1'b0;
      per_valid_o <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      pos_valid_o <= 1'b0;
      neg_valid_o <= 1'b0;
      per_valid_o <= 1'b0;
      if (any_edge) begin
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          if (sat) begin
            ovf_o    <= 1'b1;
            pos_ok_q <= 1'b0;
          end else if (edge_i.fall) begin
            pos_cnt_o   <= cnt_q;
            pos_valid_o <= 1'b1;
            pos_ok_q    <= 1'b1;
          end else begin
            neg_cnt_o   <= cnt_q;
            neg_valid_o <= 1'b1;
            pos_ok_q    <= 1'b0;
            if (pos_ok_q) begin
              per_cnt_o   <= {1'b0, pos_cnt_o} + {1'b0, cnt_q};
              per_valid_o <= 1'b1;
            end
          end
        end
      end else if (!sat) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/line_period_meter.sv
module line_period_meter
  import lpm_pkg::*;
#(
  parameter int CNT_W       = 18,
  parameter int SYNC_STAGES = 2,
  parameter bit FILT_EN     = 1'b1,
  parameter int FILT_TICKS  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic [CNT_W-1:0] pos_cnt_o,
  output logic             pos_valid_o,
  output logic [CNT_W-1:0] neg_cnt_o,
  output logic             neg_valid_o,
  output logic [CNT_W:0]   per_cnt_o,
  output logic             per_valid_o,
  output logic             ovf_o
);
  logic  line_s;
  logic  lvl;
  logic  lvl_q;
  edge_t edge_d;

  lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  lpm_deglitch #(.FILT_EN(FILT_EN), .FILT_TICKS(FILT_TICKS)) u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_s),
    .lvl_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign edge_d.rise = lvl & ~lvl_q;
  assign edge_d.fall = ~lvl & lvl_q;

  lpm_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (edge_d),
    .pos_cnt_o  (pos_cnt_o),
    .pos_valid_o(pos_valid_o),
    .neg_cnt_o  (neg_cnt_o),
    .neg_valid_o(neg_valid_o),
    .per_cnt_o  (per_cnt_o),
    .per_valid_o(per_valid_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: rtl/line_period_meter_chk.sv
module line_period_meter_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] pos_cnt_o,
  input logic             pos_valid_o,
  input logic [CNT_W-1:0] neg_cnt_o,
  input logic             neg_valid_o,
  input logic [CNT_W:0]   per_cnt_o,
  input logic             per_valid_o,
  input logic             ovf_o
);
  // R2
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!pos_valid_o && !neg_valid_o && !per_valid_o && !ovf_o
                               && per_cnt_o == '0);
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_valid_o && neg_valid_o));

  // R6
  per_with_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_valid_o |-> neg_valid_o);

  // R6
  per_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_valid_o |-> per_cnt_o == ({1'b0, pos_cnt_o} + {1'b0, neg_cnt_o}));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R7
  pos_not_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_valid_o |-> pos_cnt_o != {CNT_W{1'b1}});

  // R7
  neg_not_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_valid_o |-> neg_cnt_o != {CNT_W{1'b1}});
endmodule

bind line_period_meter line_period_meter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/line_period_meter_tb.sv
module line_period_meter_tb;
  localparam int CNT_W = 12;
  localparam int FILT  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line = 1'b0;
  logic [CNT_W-1:0] pos_cnt, neg_cnt;
  logic [CNT_W:0]   per_cnt;
  logic             pos_v, neg_v, per_v, ovf;

  int checks = 0, fails = 0;
  int n_pos = 0, n_neg = 0, n_per = 0;
  int exp_pos = 0, exp_neg = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_period_meter #(.CNT_W(CNT_W), .FILT_TICKS(FILT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .pos_cnt_o(pos_cnt), .pos_valid_o(pos_v),
    .neg_cnt_o(neg_cnt), .neg_valid_o(neg_v),
    .per_cnt_o(per_cnt), .per_valid_o(per_v), .ovf_o(ovf)
  );

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_tol(string req, int act, int exp);
    checks++;
    if (act > exp + 2 || act < exp - 2) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d +/-2", req, act, exp);
    end
  endtask

  // result monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pos_v && neg_v) chk_eq("R8 strobes coincide", 1, 0);
      if (pos_v) begin n_pos++; chk_tol("R4 high half", int'(pos_cnt), exp_pos); end
      if (neg_v) begin n_neg++; chk_tol("R5 low half", int'(neg_cnt), exp_neg); end
      if (per_v) begin n_per++; chk_tol("R6 period", int'(per_cnt), exp_pos + exp_neg); end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #($urandom_range(1, 18));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line  = 1'b0;
    tick(3);
    n_pos = 0; n_neg = 0; n_per = 0;
    rst_n = 1'b1;
    tick(10);
  endtask

  task automatic run_pattern(int hp, int hn, int k, bit glitch);
    do_reset();
    exp_pos = hp;
    exp_neg = hn;
    for (int i = 0; i < k; i++) begin
      line = 1'b1;
      if (glitch) begin
        tick(hp / 2);
        line = 1'b0;
        tick(FILT - 1);
        line = 1'b1;
        tick(hp - hp / 2 - (FILT - 1));
      end else begin
        tick(hp / 2);
        if (i == 0) chk_eq("R3 no strobe after arming edge", n_pos + n_neg + n_per, 0);
        tick(hp - hp / 2);
      end
      line = 1'b0;
      if (glitch) begin
        tick(hn / 2);
        line = 1'b1;
        tick(FILT - 2);
        line = 1'b0;
        tick(hn - hn / 2 - (FILT - 2));
      end else begin
        tick(hn);
      end
    end
    line = 1'b1;
    tick(FILT + 20);
    chk_eq(glitch ? "R1 high-half count with glitches" : "R4 high-half strobe count", n_pos, k);
    chk_eq(glitch ? "R1 low-half count with glitches" : "R5 low-half strobe count", n_neg, k);
    chk_eq("R6 period strobe count", n_per, k);
    chk_tol("R9 polarity: pos holds high length", int'(pos_cnt), hp);
    chk_eq("R7 no overflow", int'(ovf), 0);
  endtask

  initial begin
    tick(1);
    // R2
    chk_eq("R2 reset pos_valid", int'(pos_v), 0);
    chk_eq("R2 reset per_cnt", int'(per_cnt), 0);
    chk_eq("R2 reset ovf", int'(ovf), 0);

    run_pattern(100, 100, 5, 1'b0);
    run_pattern(37, 200, 5, 1'b0);
    run_pattern(500, 50, 4, 1'b0);
    run_pattern(1500, 3000, 3, 1'b0);
    run_pattern(4000, 64, 2, 1'b0);
    run_pattern(200, 180, 4, 1'b1);
    run_pattern(FILT + 6, FILT + 9, 6, 1'b0);

    // R7 overflow scenario
    do_reset();
    exp_pos = 100;
    exp_neg = 100;
    line = 1'b1;
    tick(4000);
    chk_eq("R7 ovf clear before limit", int'(ovf), 0);
    tick(300);
    line = 1'b0;
    tick(FILT + 10);
    chk_eq("R7 ovf set", int'(ovf), 1);
    chk_eq("R7 overflowed half not strobed", n_pos, 0);
    tick(100 - FILT - 10);
    line = 1'b1;
    tick(FILT + 10);
    chk_eq("R7 low half after overflow strobed", n_neg, 1);
    chk_eq("R7 no period for overflowed cycle", n_per, 0);
    tick(100 - FILT - 10);
    line = 1'b0;
    tick(100);
    line = 1'b1;
    tick(FILT + 10);
    chk_eq("R7 recovered period", n_per, 1);
    chk_eq("R7 ovf sticky", int'(ovf), 1);

    rst_n = 1'b0;
    tick(1);
    chk_eq("R2 reset clears ovf", int'(ovf), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule